// File: doc/BRIEF.md
# SMBus Indexed Block Register Slave

This block is a two-wire bus slave that gives a bus master access to a small bank of byte-wide configuration registers. The master names a starting register, states how many bytes follow, and then moves that many bytes into consecutive registers. To read, it names the starting register, issues a repeated start with the read bit set, and receives a count byte followed by register contents. The register pointer steps by one after every data byte. Every register is also presented on a flat parallel output, so neighbouring logic can use individual bits directly, for example as per-output enables.

Both bus lines are brought into the system clock domain through a two-flop synchronizer and a glitch filter, and start, stop and edge events are found from the filtered levels. The slave only ever pulls SDA low or releases it. The upper four address bits are a parameter and the lower three come from strap inputs, so up to eight of these slaves can share one bus.

Top module: `smb_idx_slave`

## Requirements
- R1: The 7-bit device address is {ADDR_HI, sa_i}. A matching address byte is ACKed. A non-matching address byte is not ACKed, and every later byte up to the next start condition is neither ACKed nor acted on.
- R2: In a write (address byte with bit 0 = 0), the offset byte, the count byte and each data byte are ACKed. Data byte k is stored in register offset+k. A count of 1 writes exactly one register.
- R3: A count byte of 0x00 is not ACKed, and no register changes for the rest of that transfer.
- R4: Once N data bytes have been written, any further data byte in the same transfer is not ACKed and is not stored.
- R5: A data byte aimed at an offset of NUM_REGS or above is ACKed but dropped, and no implemented register changes.
- R6: After a repeated start with address bit 0 = 1, the slave first returns a count byte equal to NUM_REGS - offset, or 0x00 when offset >= NUM_REGS. It then returns registers offset, offset+1 and so on. Offsets of NUM_REGS or above read as 0x00.
- R7: A master NACK ends a read, and the slave releases SDA. A stop that comes before N bytes have been read returns the slave to idle, and the next transfer works normally.
- R8: A start or stop condition at any bit position aborts the current transfer. A partly received data byte is never stored. A start makes the next byte an address byte.
- R9: SDA is open-drain. sda_pull_o = 1 pulls the line low, and the slave only begins pulling while SCL is low.
- R10: A pulse on SCL or SDA that lasts fewer than FILT_LEN system clock cycles has no effect on the transfer.
- R11: After reset, all registers are 0x00 and SDA is released.
- R12: Register k appears on regs_o[8k+7:8k].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sa_i | input | 3 | Strap inputs giving the low address bits |
| sda_pull_o | output | 1 | 1 pulls SDA low, 0 releases it |
| regs_o | output | NUM_REGS*8 | All registers, register k in bits [8k+7:8k] |

## Verification
A level change on a bus pin reaches the protocol logic after the two synchronizer flops and FILT_LEN filter cycles. One more register stage follows, so an ACK or data bit appears on sda_pull_o about FILT_LEN+3 system cycles after SCL falls at the pin. The bench holds each SCL phase for 20 cycles and reads the resolved SDA line 10 cycles after it raises SCL, which is well after that latency and well before the next edge. A register write takes effect about the same number of cycles after the falling SCL edge that follows the eighth data bit. The bench compares regs_o with its own model only after the stop condition, many cycles later. Address matching is swept over all 64 pairs of strap value and address low bits.

// File: rtl/smb_idx_pkg.sv
// Shared types for the indexed block register slave.
package smb_idx_pkg;
    // Protocol phase of the slave.
    typedef enum logic [2:0] {
        S_IDLE,   // no transfer addressed to us
        S_ADDR,   // receiving address byte
        S_OFFS,   // receiving register offset
        S_CNT,    // receiving byte count
        S_WDAT,   // receiving data bytes
        S_TX,     // transmitting count then data
        S_IGN     // ignoring bus until next start/stop
    } smb_state_e;
endpackage

// File: rtl/smb_line_filter.sv
// Two-flop synchronizer followed by a persistence filter for one bus line.
// The output follows the synchronized input only after the input has held
// the new level for FILT_LEN consecutive cycles. Assumes FILT_LEN >= 1.
module smb_line_filter #(
    parameter int   FILT_LEN = 3,
    parameter logic RST_LVL  = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] cnt_q;
    logic          out_q;

    // Synchronize, then accept a new level only after it persists.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= {2{RST_LVL}};
            cnt_q  <= '0;
            out_q  <= RST_LVL;
        end else begin
            sync_q <= {sync_q[0], line_i};
            if (sync_q[1] != out_q) begin
                if (cnt_q == CW'(FILT_LEN - 1)) begin
                    out_q <= sync_q[1];
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end else begin
                cnt_q <= '0;
            end
        end
    end

    assign line_o = out_q;
endmodule

// File: rtl/smb_regbank.sv
// Byte-wide register bank with one write port, one read port and a flat
// parallel view. Indices at or beyond NUM_REGS are dropped on write and read
// as zero. Assumes NUM_REGS >= 2 and NUM_REGS <= 2**PW.
module smb_regbank #(
    parameter int NUM_REGS = 8,
    parameter int PW       = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [PW-1:0]         wr_idx,
    input  logic [7:0]            wr_data,
    input  logic [PW-1:0]         rd_idx,
    output logic [7:0]            rd_data,
    output logic [NUM_REGS*8-1:0] regs_flat
);
    localparam int IW = $clog2(NUM_REGS);

    logic [7:0] mem_q [NUM_REGS];
    logic       wr_hit;
    logic       rd_hit;

    assign wr_hit = wr_en && (32'(wr_idx) < NUM_REGS);
    assign rd_hit = (32'(rd_idx) < NUM_REGS);

    // Clear on reset, store one byte per accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) mem_q[i] <= 8'h00;
        end else if (wr_hit) begin
            mem_q[wr_idx[IW-1:0]] <= wr_data;
        end
    end

    // Read mux with zero fill above the implemented range.
    always_comb begin
        rd_data = rd_hit ? mem_q[rd_idx[IW-1:0]] : 8'h00;
    end

    for (genvar k = 0; k < NUM_REGS; k++) begin : g_flat
        assign regs_flat[8*k +: 8] = mem_q[k];
    end
endmodule

// File: rtl/smb_idx_slave.sv
// Two-wire bus slave with indexed block write and indexed block read.
// Write: addr(W), offset, count N (nonzero), N data bytes. Read: addr(W),
// offset, repeated start, addr(R), then the slave sends a count byte and data.
// Assumes the system clock oversamples SCL by well over FILT_LEN+4 cycles per
// phase. No clock stretching.
module smb_idx_slave
    import smb_idx_pkg::*;
#(
    parameter logic [3:0] ADDR_HI  = 4'b1101,
    parameter int         NUM_REGS = 8,
    parameter int         FILT_LEN = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    input  logic [2:0]            sa_i,
    output logic                  sda_pull_o,
    output logic [NUM_REGS*8-1:0] regs_o
);
    localparam int PW = 8;

    logic [1:0] raw_lines;
    logic [1:0] filt_lines;
    logic       scl_f, sda_f, scl_d, sda_d;
    logic       ev_start, ev_stop, ev_rise, ev_fall;

    smb_state_e    state_q, pend_q, pend_c;
    logic [3:0]    bitcnt_q;
    logic [7:0]    shreg_q, txb_q, remain_q, avail_c, rd_data;
    logic [PW-1:0] ptr_q;
    logic          mnack_q, ack_c, wr_en;

    assign raw_lines = {sda_i, scl_i};

    for (genvar g = 0; g < 2; g++) begin : g_filt
        smb_line_filter #(.FILT_LEN(FILT_LEN), .RST_LVL(1'b1)) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_i (raw_lines[g]),
            .line_o (filt_lines[g])
        );
    end

    assign scl_f    = filt_lines[0];
    assign sda_f    = filt_lines[1];
    assign ev_start = scl_f & scl_d & sda_d & ~sda_f;
    assign ev_stop  = scl_f & scl_d & ~sda_d & sda_f;
    assign ev_rise  = scl_f & ~scl_d;
    assign ev_fall  = ~scl_f & scl_d;

    smb_regbank #(.NUM_REGS(NUM_REGS), .PW(PW)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (ptr_q),
        .wr_data   (shreg_q),
        .rd_idx    (ptr_q),
        .rd_data   (rd_data),
        .regs_flat (regs_o)
    );

    // Count byte returned in a read: registers left from the pointer.
    always_comb begin
        avail_c = (32'(ptr_q) < NUM_REGS) ? 8'(NUM_REGS - 32'(ptr_q)) : 8'h00;
    end

    // ACK decision and follow-on phase for a fully received byte.
    always_comb begin
        ack_c  = 1'b0;
        pend_c = S_IGN;
        case (state_q)
            S_ADDR: if (shreg_q[7:1] == {ADDR_HI, sa_i}) begin
                ack_c  = 1'b1;
                pend_c = shreg_q[0] ? S_TX : S_OFFS;
            end
            S_OFFS: begin
                ack_c  = 1'b1;
                pend_c = S_CNT;
            end
            S_CNT: if (shreg_q != 8'h00) begin
                ack_c  = 1'b1;
                pend_c = S_WDAT;
            end
            S_WDAT: if (remain_q != 8'h00) begin
                ack_c  = 1'b1;
                pend_c = S_WDAT;
            end
            default: ;
        endcase
        wr_en = ev_fall && (bitcnt_q == 4'd8) && (state_q == S_WDAT)
                && (remain_q != 8'h00) && !ev_start && !ev_stop;
    end

    // Protocol sequencer: bit counting, shifting, ACK and data drive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d      <= 1'b1;
            sda_d      <= 1'b1;
            state_q    <= S_IDLE;
            pend_q     <= S_IDLE;
            bitcnt_q   <= '0;
            shreg_q    <= '0;
            txb_q      <= '0;
            ptr_q      <= '0;
            remain_q   <= '0;
            mnack_q    <= 1'b0;
            sda_pull_o <= 1'b0;
        end else begin
            scl_d <= scl_f;
            sda_d <= sda_f;
            if (ev_stop) begin
                state_q    <= S_IDLE;
                bitcnt_q   <= '0;
                sda_pull_o <= 1'b0;
            end else if (ev_start) begin
                state_q    <= S_ADDR;
                bitcnt_q   <= '0;
                sda_pull_o <= 1'b0;
            end else if (state_q != S_IDLE && state_q != S_IGN) begin
                if (ev_rise) begin
                    bitcnt_q <= bitcnt_q + 4'd1;
                    if (bitcnt_q < 4'd8) shreg_q <= {shreg_q[6:0], sda_f};
                    else                 mnack_q <= sda_f;
                end
                if (ev_fall) begin
                    if (bitcnt_q == 4'd8) begin
                        if (state_q == S_TX) begin
                            sda_pull_o <= 1'b0;
                        end else begin
                            sda_pull_o <= ack_c;
                            pend_q     <= pend_c;
                            if (state_q == S_OFFS) ptr_q    <= shreg_q;
                            if (state_q == S_CNT)  remain_q <= shreg_q;
                            if (wr_en) begin
                                ptr_q    <= ptr_q + 1'b1;
                                remain_q <= remain_q - 8'd1;
                            end
                        end
                    end else if (bitcnt_q == 4'd9) begin
                        bitcnt_q <= '0;
                        if (state_q == S_TX) begin
                            if (mnack_q) begin
                                state_q    <= S_IGN;
                                sda_pull_o <= 1'b0;
                            end else begin
                                txb_q      <= rd_data;
                                ptr_q      <= ptr_q + 1'b1;
                                sda_pull_o <= ~rd_data[7];
                            end
                        end else begin
                            state_q <= pend_q;
                            if (pend_q == S_TX) begin
                                txb_q      <= avail_c;
                                sda_pull_o <= ~avail_c[7];
                            end else begin
                                sda_pull_o <= 1'b0;
                            end
                        end
                    end else if (state_q == S_TX && bitcnt_q != 4'd0) begin
                        sda_pull_o <= ~txb_q[3'd7 - bitcnt_q[2:0]];
                    end
                end
            end
        end
    end
endmodule

// File: rtl/smb_idx_slave_chk.sv
// Assertion checker for smb_idx_slave, attached by bind. Observes the
// filtered SCL level, sequencer state and the block outputs.
module smb_idx_slave_chk
    import smb_idx_pkg::*;
#(
    parameter int NUM_REGS = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  scl_f,
    input logic                  ev_start,
    input smb_state_e            state,
    input logic [3:0]            bitcnt,
    input logic                  sda_pull,
    input logic [NUM_REGS*8-1:0] regs
);
    // R11: reset leaves SDA released and registers cleared
    p_reset_clear_r11: assert property (@(posedge clk)
        !rst_n |=> (!sda_pull && regs == '0));

    // R9: the slave starts pulling SDA only while SCL is low
    p_pull_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull) |-> !scl_f);

    // R7: idle or ignoring means SDA released
    p_quiet_when_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE || state == S_IGN) |-> !sda_pull);

    // R3: registers change only out of the data-receive phase
    p_write_only_wdat_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(regs) |-> $past(state) == S_WDAT);

    // R8: a start condition restarts at the address byte
    p_start_restarts_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ev_start |=> (state == S_ADDR && bitcnt == 4'd0));

    // R8: bit position stays within a byte plus its ACK slot
    p_bitcnt_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bitcnt <= 4'd9);
endmodule

bind smb_idx_slave smb_idx_slave_chk #(.NUM_REGS(NUM_REGS)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_f    (scl_f),
    .ev_start (ev_start),
    .state    (state_q),
    .bitcnt   (bitcnt_q),
    .sda_pull (sda_pull_o),
    .regs     (regs_o)
);

// File: tb/smb_idx_slave_tb.sv
// Self-checking bench: acts as bus master, keeps its own register model.
module smb_idx_slave_tb_top;
    localparam int NR = 8;
    localparam logic [3:0] HI = 4'b1101;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1, m_sda = 1'b1;
    logic [2:0] sa = 3'd0;
    logic sda_pull;
    logic [NR*8-1:0] regs;
    logic sda_line;

    int n_tests = 0, n_fail = 0;
    int pull_hi_err = 0;
    logic done = 1'b0;
    logic glitch_scl = 1'b0, glitch_sda = 1'b0;

    logic [7:0] exp_r [NR];
    logic [7:0] wbuf [16];
    logic       abuf [20];
    logic [7:0] rbuf [16];
    logic [7:0] rcnt;

    always #5 clk = ~clk;

    assign sda_line = m_sda & ~sda_pull;

    smb_idx_slave #(.ADDR_HI(HI), .NUM_REGS(NR), .FILT_LEN(3)) dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
        .sa_i(sa), .sda_pull_o(sda_pull), .regs_o(regs)
    );

    // R9 monitor: pull must not begin while the master holds SCL high
    logic pull_d = 1'b0;
    always @(negedge clk) begin
        if (rst_n && sda_pull && !pull_d && m_scl) pull_hi_err++;
        pull_d <= sda_pull;
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic w(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_w(input logic b);
        w(10); m_sda = b;
        if (glitch_scl) begin w(4); m_scl = 1'b1; w(1); m_scl = 1'b0; w(5); end
        else w(10);
        m_scl = 1'b1;
        if (glitch_sda && b) begin w(5); m_sda = 1'b0; w(2); m_sda = 1'b1; w(13); end
        else w(20);
        m_scl = 1'b0;
    endtask

    task automatic bit_r(output logic b);
        w(10); m_sda = 1'b1; w(10); m_scl = 1'b1; w(10);
        b = sda_line; w(10); m_scl = 1'b0;
    endtask

    task automatic start_c;
        w(10); m_sda = 1'b1; w(10); m_scl = 1'b1; w(20);
        m_sda = 1'b0; w(20); m_scl = 1'b0;
    endtask

    task automatic stop_c;
        w(10); m_sda = 1'b0; w(10); m_scl = 1'b1; w(20);
        m_sda = 1'b1; w(20);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic a;
        for (int i = 7; i >= 0; i--) bit_w(b[i]);
        bit_r(a);
        ack = ~a;
    endtask

    task automatic recv_byte(output logic [7:0] b, input logic give_ack);
        logic x;
        for (int i = 7; i >= 0; i--) begin bit_r(x); b[i] = x; end
        bit_w(~give_ack);
    endtask

    task automatic wr_txn(input logic [6:0] a7, input logic [7:0] off,
                          input logic [7:0] cnt, input int nd);
        logic a;
        start_c;
        send_byte({a7, 1'b0}, a); abuf[0] = a;
        send_byte(off, a);        abuf[1] = a;
        send_byte(cnt, a);        abuf[2] = a;
        for (int i = 0; i < nd; i++) begin send_byte(wbuf[i], a); abuf[3+i] = a; end
        stop_c;
        w(20);
    endtask

    task automatic rd_txn(input logic [6:0] a7, input logic [7:0] off, input int nd);
        logic a;
        logic [7:0] b;
        start_c;
        send_byte({a7, 1'b0}, a); abuf[0] = a;
        send_byte(off, a);        abuf[1] = a;
        start_c;
        send_byte({a7, 1'b1}, a); abuf[2] = a;
        recv_byte(b, nd > 0); rcnt = b;
        for (int i = 0; i < nd; i++) begin recv_byte(b, i < nd - 1); rbuf[i] = b; end
        stop_c;
        w(20);
    endtask

    task automatic chk_regs(input string tag);
        for (int k = 0; k < NR; k++)
            chk($sformatf("%s R12 reg%0d", tag, k), int'(regs[8*k +: 8]), int'(exp_r[k]));
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic a;
        logic [6:0] A;
        for (int k = 0; k < NR; k++) exp_r[k] = 8'h00;
        w(5); rst_n = 1'b1; w(10);

        // R11 reset state
        chk("R11 sda released", int'(sda_pull), 0);
        chk_regs("R11 reset");

        // R1 strap sweep: ACK only when low address bits equal the straps
        for (int s = 0; s < 8; s++) begin
            sa = 3'(s);
            for (int lo = 0; lo < 8; lo++) begin
                start_c;
                send_byte({HI, 3'(lo), 1'b0}, a);
                stop_c;
                chk($sformatf("R1 ack sa=%0d lo=%0d", s, lo), int'(a), int'(lo == s));
            end
        end
        sa = 3'd5;
        A  = {HI, 3'd5};

        // R1 mismatched address: nothing ACKed, nothing stored
        wbuf[0] = 8'h5A;
        wr_txn({HI, 3'd4}, 8'd0, 8'd1, 1);
        chk("R1 mismatch addr ack", int'(abuf[0]), 0);
        chk("R1 ignored offset ack", int'(abuf[1]), 0);
        chk("R1 ignored data ack", int'(abuf[3]), 0);
        chk_regs("R1 mismatch");

        // R2 block write of three bytes from offset 2
        wbuf[0] = 8'hA1; wbuf[1] = 8'hA2; wbuf[2] = 8'hA3;
        wr_txn(A, 8'd2, 8'd3, 3);
        for (int i = 0; i < 6; i++) chk($sformatf("R2 ack byte%0d", i), int'(abuf[i]), 1);
        exp_r[2] = 8'hA1; exp_r[3] = 8'hA2; exp_r[4] = 8'hA3;
        chk_regs("R2 block");

        // R2 single write, count 1, to the last register
        wbuf[0] = 8'h7E;
        wr_txn(A, 8'd7, 8'd1, 1);
        chk("R2 single ack", int'(abuf[3]), 1);
        exp_r[7] = 8'h7E;
        chk_regs("R2 single");

        // R3 zero count refused
        wbuf[0] = 8'h55;
        wr_txn(A, 8'd0, 8'd0, 1);
        chk("R3 zero count nack", int'(abuf[2]), 0);
        chk("R3 data after zero nack", int'(abuf[3]), 0);
        chk_regs("R3 zero");

        // R4 surplus byte beyond N
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
        wr_txn(A, 8'd0, 8'd2, 3);
        chk("R4 byte0 ack", int'(abuf[3]), 1);
        chk("R4 byte1 ack", int'(abuf[4]), 1);
        chk("R4 surplus nack", int'(abuf[5]), 0);
        exp_r[0] = 8'h11; exp_r[1] = 8'h22;
        chk_regs("R4 surplus");

        // R5 run past the last register
        wbuf[0] = 8'hC6; wbuf[1] = 8'hC7; wbuf[2] = 8'hC8; wbuf[3] = 8'hC9;
        wr_txn(A, 8'd6, 8'd4, 4);
        for (int i = 3; i < 7; i++) chk($sformatf("R5 ack byte%0d", i - 3), int'(abuf[i]), 1);
        exp_r[6] = 8'hC6; exp_r[7] = 8'hC7;
        chk_regs("R5 past end");

        // R6 reads: count byte then consecutive registers
        rd_txn(A, 8'd1, 3);
        chk("R6 addr read ack", int'(abuf[2]), 1);
        chk("R6 count off1", int'(rcnt), NR - 1);
        for (int i = 0; i < 3; i++) chk($sformatf("R6 data off1+%0d", i), int'(rbuf[i]), int'(exp_r[1+i]));
        rd_txn(A, 8'd6, 4);
        chk("R6 count off6", int'(rcnt), NR - 6);
        for (int i = 0; i < 4; i++)
            chk($sformatf("R6 data off6+%0d", i), int'(rbuf[i]), (6 + i < NR) ? int'(exp_r[6+i]) : 0);
        rd_txn(A, 8'd9, 1);
        chk("R6 count beyond", int'(rcnt), 0);
        chk("R6 data beyond", int'(rbuf[0]), 0);

        // R7 early end of read, then a normal write
        rd_txn(A, 8'd0, 1);
        chk("R7 count", int'(rcnt), NR);
        chk("R7 first data", int'(rbuf[0]), int'(exp_r[0]));
        chk("R7 released after stop", int'(sda_pull), 0);
        wbuf[0] = 8'h5C;
        wr_txn(A, 8'd5, 8'd1, 1);
        chk("R7 next write ack", int'(abuf[3]), 1);
        exp_r[5] = 8'h5C;
        chk_regs("R7 recover");

        // R8 stop in mid data byte: no partial store
        start_c;
        send_byte({A, 1'b0}, a);
        send_byte(8'd3, a);
        send_byte(8'd1, a);
        bit_w(1'b1); bit_w(1'b0); bit_w(1'b1); bit_w(1'b0);
        stop_c; w(20);
        chk("R8 released after abort", int'(sda_pull), 0);
        chk_regs("R8 stop abort");

        // R8 repeated start in mid count byte, then a full write
        start_c;
        send_byte({A, 1'b0}, a);
        send_byte(8'd4, a);
        bit_w(1'b0); bit_w(1'b0); bit_w(1'b0);
        start_c;
        send_byte({A, 1'b0}, a); chk("R8 addr after restart ack", int'(a), 1);
        send_byte(8'd4, a);
        send_byte(8'd1, a);
        send_byte(8'h44, a);     chk("R8 data after restart ack", int'(a), 1);
        stop_c; w(20);
        exp_r[4] = 8'h44;
        chk_regs("R8 restart");

        // R10 short SCL pulses while low, then short SDA dips while SCL high
        glitch_scl = 1'b1;
        wbuf[0] = 8'h96;
        wr_txn(A, 8'd0, 8'd1, 1);
        glitch_scl = 1'b0;
        chk("R10 scl glitch ack", int'(abuf[3]), 1);
        glitch_sda = 1'b1;
        wbuf[0] = 8'h6F;
        wr_txn(A, 8'd1, 8'd1, 1);
        glitch_sda = 1'b0;
        chk("R10 sda glitch ack", int'(abuf[3]), 1);
        exp_r[0] = 8'h96; exp_r[1] = 8'h6F;
        chk_regs("R10 glitch");

        // R9 open-drain timing over the whole run
        chk("R9 pull began with SCL high", pull_hi_err, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule